// File: doc/BRIEF.md
# SD Card Clock Divisor Search Unit

This block works out the divider settings for an SD card bus clock and then produces that clock as a one-cycle enable pulse in the reference clock domain. Software supplies three things: the reference frequency, which is the frequency of `clk`; the wanted card clock frequency; and two mode flags. It then raises `start` for one cycle. The unit clears the clock enables and the divider field of its control word. It then tries one candidate setting per clock cycle. First it raises a power-of-two prescaler as far as needed, and then it steps a linear divisor from 1 up to 16. The outcome is packed into the control word, and all three clock enables are turned back on in the same write.

No divider is used. Each step compares a product against the reference instead, which gives the same answer as the floor-division rule stated in the requirements. The divided-clock enable output runs only while the peripheral enable bit of the word is set. It pulses once every prescaler × divisor cycles of `clk`.

Top module: `sd_clkdiv_search`

## Requirements
- R1: In `ctrlWord`, bits 7:4 hold the divisor minus one and bits 15:8 hold the prescaler code. Bit 3 and bits 31:16 are always zero.
- R2: Bit 2 of `ctrlWord` is the peripheral clock enable, bit 1 the host clock enable and bit 0 the interface clock enable. The three bits are always equal, and they are set by the same write that stores a nonzero-target result (word = field | 3'b111).
- R3: From the cycle after an accepted `start` until the result is written, `ctrlWord[15:0]` is zero.
- R4: A target of zero ends with `ctrlWord` all zero and `done` pulsed, and `sdClkEn` never pulses afterwards.
- R5: The prescaler starts at 2. It doubles while floor(ref/prescaler/16) > target and prescaler < 256.
- R6: After that, the divisor starts at 1. It increments while floor(ref/prescaler/divisor) > target and divisor < 16.
- R7: The prescaler code is prescaler >> 1 when `ddrMode` is 0 and prescaler >> 2 when `ddrMode` is 1.
- R8: With `singleRateStart` = 1 and `ddrMode` = 0, the prescaler starts at 1 instead of 2. With `ddrMode` = 1 it starts at 2.
- R9: `busy` is high from the cycle after an accepted `start` until the word is written. `done` is high for exactly one cycle, the first cycle in which the new word is visible, and `busy` is low in that cycle. A `start` raised while `busy` is high is ignored, and the word does not change while idle.
- R10: While bit 2 of `ctrlWord` is set, `sdClkEn` pulses once every prescaler × divisor cycles. While bit 2 is clear, `sdClkEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; its frequency is the value given on `refFreq` |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to compute and apply a new setting |
| singleRateStart | input | 1 | Start the prescaler at 1 unless DDR is selected |
| ddrMode | input | 1 | Dual data rate: changes the start value and the prescaler code |
| refFreq | input | REF_W | Reference frequency, sampled on `start` |
| targetFreq | input | REF_W | Wanted card clock frequency, sampled on `start` |
| ctrlWord | output | 32 | Clock control word: enables and divider field |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the new word is written |
| sdClkEn | output | 1 | Divided clock enable pulse |

## Verification
The assertions assume that reset is held low from time zero until the first clock edges have passed. They also assume that `start` is only acted on while the unit is idle. This lets them treat every change of the word outside a search as an error. The stimulus keeps `refFreq` and `targetFreq` within a 16-bit setting, so the bench model can use ordinary integer division and compare its result against the multiply-compare datapath. It drives `start` for one cycle per run, and in one case raises it again during a search to show that it is ignored.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int CTRL_W     = 32;
  localparam int DIV_LSB    = 4;
  localparam int PRE_LSB    = 8;
  localparam int EN_PER_BIT = 2;
  localparam int EN_HST_BIT = 1;
  localparam int EN_IF_BIT  = 0;
  localparam int EN_COUNT   = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_DIV,
    ST_APPLY
  } srchState_t;

  typedef struct packed {
    logic load;
    logic preDouble;
    logic divInc;
    logic apply;
  } dpStrobe_t;

endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      tgtZero,
  input  logic      preMore,
  input  logic      divMore,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  srchState_t state;
  srchState_t stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNxt    = ST_PRE;
        end
      end
      ST_PRE: begin
        if (tgtZero) begin
          stateNxt = ST_APPLY;
        end else if (preMore) begin
          strobe.preDouble = 1'b1;
        end else begin
          stateNxt = ST_DIV;
        end
      end
      ST_DIV: begin
        if (divMore) begin
          strobe.divInc = 1'b1;
        end else begin
          stateNxt = ST_APPLY;
        end
      end
      ST_APPLY: begin
        strobe.apply = 1'b1;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= strobe.apply;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sdclk_dpath.sv
module sdclk_dpath
  import sdclk_pkg::*;
#(
  parameter int REF_W   = 32,
  parameter int PRE_MAX = 256,
  parameter int DIV_MAX = 16,
  localparam int PRE_W      = $clog2(PRE_MAX) + 1,
  localparam int DIV_W      = $clog2(DIV_MAX) + 1,
  localparam int PER_W      = PRE_W + DIV_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic              singleRateStart,
  input  logic              ddrMode,
  input  logic [REF_W-1:0]  refFreq,
  input  logic [REF_W-1:0]  targetFreq,
  output logic              tgtZero,
  output logic              preMore,
  output logic              divMore,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [PER_W-1:0]  period
);

  localparam int PROD_W     = REF_W + 1 + PRE_W + DIV_W;
  localparam int DIV_CODE_W = $clog2(DIV_MAX);
  localparam int PRE_CODE_W = PRE_W - 1;

  logic [REF_W-1:0]  refQ;
  logic [REF_W-1:0]  tgtQ;
  logic              ddrQ;
  logic [PRE_W-1:0]  preQ;
  logic [DIV_W-1:0]  divQ;

  // Floor-division tests rewritten as products:
  // floor(ref/(p*d)) > t  <=>  (t+1)*p*d <= ref
  logic [PROD_W-1:0] tgtExt;
  logic [PROD_W-1:0] refExt;
  logic [PROD_W-1:0] preProbe;
  logic [PROD_W-1:0] divProbe;

  assign tgtExt   = PROD_W'(tgtQ) + PROD_W'(1);
  assign refExt   = PROD_W'(refQ);
  assign preProbe = tgtExt * PROD_W'(preQ) * PROD_W'(DIV_MAX);
  assign divProbe = tgtExt * PROD_W'(preQ) * PROD_W'(divQ);

  assign tgtZero = (tgtQ == '0);
  assign preMore = (preProbe <= refExt) && (preQ < PRE_W'(PRE_MAX));
  assign divMore = (divProbe <= refExt) && (divQ < DIV_W'(DIV_MAX));

  logic [DIV_W-1:0]      divLess;
  logic [PRE_W-1:0]      preShift;
  logic [DIV_CODE_W-1:0] divCode;
  logic [PRE_CODE_W-1:0] preCode;
  logic [CTRL_W-1:0]     newWord;

  assign divLess  = divQ - DIV_W'(1);
  assign preShift = ddrQ ? (preQ >> 2) : (preQ >> 1);
  assign divCode  = divLess[DIV_CODE_W-1:0];
  assign preCode  = preShift[PRE_CODE_W-1:0];

  localparam int EN_POS [EN_COUNT] = '{EN_IF_BIT, EN_HST_BIT, EN_PER_BIT};

  logic [CTRL_W-1:0] enMask;
  for (genvar g = 0; g < EN_COUNT; g++) begin : g_enBit
    assign enMask[EN_POS[g]] = 1'b1;
  end
  for (genvar h = 0; h < CTRL_W; h++) begin : g_enFill
    if (h != EN_IF_BIT && h != EN_HST_BIT && h != EN_PER_BIT) begin : g_zero
      assign enMask[h] = 1'b0;
    end
  end

  always_comb begin
    newWord = enMask;
    newWord[DIV_LSB +: DIV_CODE_W] = divCode;
    newWord[PRE_LSB +: PRE_CODE_W] = preCode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refQ     <= '0;
      tgtQ     <= '0;
      ddrQ     <= 1'b0;
      preQ     <= PRE_W'(2);
      divQ     <= DIV_W'(1);
      ctrlWord <= '0;
      period   <= PER_W'(1);
    end else begin
      if (strobe.load) begin
        refQ     <= refFreq;
        tgtQ     <= targetFreq;
        ddrQ     <= ddrMode;
        preQ     <= (singleRateStart && !ddrMode) ? PRE_W'(1) : PRE_W'(2);
        divQ     <= DIV_W'(1);
        ctrlWord <= '0;
      end
      if (strobe.preDouble) begin
        preQ <= preQ << 1;
      end
      if (strobe.divInc) begin
        divQ <= divQ + DIV_W'(1);
      end
      if (strobe.apply) begin
        if (tgtZero) begin
          ctrlWord <= '0;
        end else begin
          ctrlWord <= newWord;
          period   <= PER_W'(preQ) * PER_W'(divQ);
        end
      end
    end
  end

endmodule

// File: rtl/sdclk_pulse.sv
module sdclk_pulse #(
  parameter int PER_W = 14
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic [PER_W-1:0] period,
  output logic             sdClkEn
);

  logic [PER_W-1:0] count;
  logic             wrap;

  assign wrap    = (count >= period - PER_W'(1));
  assign sdClkEn = runEn && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!runEn || wrap) begin
      count <= '0;
    end else begin
      count <= count + PER_W'(1);
    end
  end

endmodule

// File: rtl/sd_clkdiv_search.sv
module sd_clkdiv_search
  import sdclk_pkg::*;
#(
  parameter int REF_W   = 32,
  parameter int PRE_MAX = 256,
  parameter int DIV_MAX = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              singleRateStart,
  input  logic              ddrMode,
  input  logic [REF_W-1:0]  refFreq,
  input  logic [REF_W-1:0]  targetFreq,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              busy,
  output logic              done,
  output logic              sdClkEn
);

  localparam int PER_W = ($clog2(PRE_MAX) + 1) + ($clog2(DIV_MAX) + 1);

  dpStrobe_t        strobe;
  logic             tgtZero;
  logic             preMore;
  logic             divMore;
  logic [PER_W-1:0] period;

  sdclk_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tgtZero (tgtZero),
    .preMore (preMore),
    .divMore (divMore),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  sdclk_dpath #(
    .REF_W   (REF_W),
    .PRE_MAX (PRE_MAX),
    .DIV_MAX (DIV_MAX)
  ) u_dpath (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobe          (strobe),
    .singleRateStart (singleRateStart),
    .ddrMode         (ddrMode),
    .refFreq         (refFreq),
    .targetFreq      (targetFreq),
    .tgtZero         (tgtZero),
    .preMore         (preMore),
    .divMore         (divMore),
    .ctrlWord        (ctrlWord),
    .period          (period)
  );

  sdclk_pulse #(
    .PER_W (PER_W)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .runEn   (ctrlWord[EN_PER_BIT]),
    .period  (period),
    .sdClkEn (sdClkEn)
  );

endmodule

// File: rtl/sd_clkdiv_search_chk.sv
module sd_clkdiv_search_chk #(
  parameter int REF_W = 32
)(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [31:0]      ctrlWord,
  input logic             busy,
  input logic             done,
  input logic             sdClkEn
);

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWord[31:16] == 16'h0) && !ctrlWord[3]); // R1

  AST_ENABLES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWord[2:0] == 3'b000) || (ctrlWord[2:0] == 3'b111)); // R2

  AST_CLEARED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ctrlWord[15:0] == 16'h0)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_IDLE_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ctrlWord)); // R9

  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlWord[2] |-> !sdClkEn); // R10

endmodule

bind sd_clkdiv_search sd_clkdiv_search_chk #(.REF_W(REF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ctrlWord (ctrlWord),
  .busy     (busy),
  .done     (done),
  .sdClkEn  (sdClkEn)
);

// File: tb/sd_clkdiv_search_bench.sv
module sd_clkdiv_search_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REF_W      = 16;
  localparam int WATCHDOG   = 190000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             singleRateStart = 1'b0;
  logic             ddrMode = 1'b0;
  logic [REF_W-1:0] refFreq = '0;
  logic [REF_W-1:0] targetFreq = '0;
  logic [31:0]      ctrlWord;
  logic             busy;
  logic             done;
  logic             sdClkEn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_clkdiv_search #(.REF_W(REF_W)) u_sd_clkdiv_search (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .singleRateStart (singleRateStart),
    .ddrMode         (ddrMode),
    .refFreq         (refFreq),
    .targetFreq      (targetFreq),
    .ctrlWord        (ctrlWord),
    .busy            (busy),
    .done            (done),
    .sdClkEn         (sdClkEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Model from R5..R8 and R1/R2 using plain integer division
  task automatic model(input int r, input int t, input bit sr, input bit dd,
                       output int word, output int per);
    int pre;
    int dv;
    pre = (sr && !dd) ? 1 : 2;
    if (t == 0) begin
      word = 0;
      per  = 0;
      return;
    end
    while ((r / pre / 16 > t) && (pre < 256)) pre = pre * 2;
    dv = 1;
    while ((r / pre / dv > t) && (dv < 16)) dv = dv + 1;
    word = ((pre >> (dd ? 2 : 1)) << 8) | ((dv - 1) << 4) | 7;
    per  = pre * dv;
  endtask

  // Launch one search; returns word seen with done and whether R3/R9 held
  task automatic runSearch(input int r, input int t, input bit sr, input bit dd,
                           output int word, output bit searchOk, output bit gotDone);
    int cyc;
    @(negedge clk);
    refFreq = REF_W'(r);
    targetFreq = REF_W'(t);
    singleRateStart = sr;
    ddrMode = dd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    searchOk = 1'b1;
    while (!done && cyc < 100) begin
      if (!busy || ctrlWord[15:0] != 16'h0 || sdClkEn) searchOk = 1'b0;
      @(negedge clk);
      cyc++;
    end
    gotDone = done;
    word = int'(ctrlWord);
    if (busy) searchOk = 1'b0;
  endtask

  task automatic measurePeriod(output int gap);
    int cyc;
    gap = -1;
    cyc = 0;
    while (!sdClkEn && cyc < 100) begin @(negedge clk); cyc++; end
    if (!sdClkEn) return;
    @(negedge clk);
    cyc = 1;
    while (!sdClkEn && cyc < 100) begin @(negedge clk); cyc++; end
    if (sdClkEn) gap = cyc;
  endtask

  task automatic sweepOne(input int r, input int t, input bit sr, input bit dd);
    int expWord;
    int expPer;
    int gotWord;
    int gap;
    bit okSearch;
    bit gotDone;
    int pulses;
    model(r, t, sr, dd, expWord, expPer);
    runSearch(r, t, sr, dd, gotWord, okSearch, gotDone);
    check(okSearch && gotDone, "R3/R9 search window", int'(okSearch), 1);
    if (t == 0) begin
      check(gotWord == 0, "R4 zero target word", gotWord, 0);
      pulses = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sdClkEn) pulses++;
      end
      check(pulses == 0, "R4 no pulses", pulses, 0);
    end else begin
      check(gotWord == expWord, dd ? "R7 ddr word" : (sr ? "R8 single-rate word" : "R5/R6 word"),
            gotWord, expWord);
      if (expPer <= 40) begin
        measurePeriod(gap);
        check(gap == expPer, "R10 pulse period", gap, expPer);
      end
    end
  endtask

  initial begin
    int refs [3] = '{50000, 1000, 37};
    int w1;
    int w2;
    int e1;
    int p1;
    int cyc;
    bit ok;
    bit gd;
    bit sawBusy;
    repeat (3) @(negedge clk);
    // reset state
    check(ctrlWord == 32'h0, "R2 reset word", int'(ctrlWord), 0);
    check(!busy && !done && !sdClkEn, "R9 reset flags", int'({busy, done, sdClkEn}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (refs[ri]) begin
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 64; k++) sweepOne(refs[ri], k, m[0], m[1]);
        for (int s = 0; s < 16; s++) begin
          if ((refs[ri] >> s) > 63) sweepOne(refs[ri], refs[ri] >> s, m[0], m[1]);
        end
      end
    end

    // R1: field layout on a known case (ref 1000, target 30, plain mode):
    // pre 2 -> 1000/2/16=31>30 -> 4; 1000/4/16=15; div: 250>30 .. div 9 -> 27
    model(1000, 30, 1'b0, 1'b0, e1, p1);
    runSearch(1000, 30, 1'b0, 1'b0, w1, ok, gd);
    check(w1[7:4] == 4'd8 && w1[15:8] == 8'd2 && w1[2:0] == 3'b111 && w1[31:16] == 0,
          "R1 field layout", w1, e1);

    // R9: start during search is ignored
    @(negedge clk);
    refFreq = 16'd50000; targetFreq = 16'd3; singleRateStart = 1'b0; ddrMode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    targetFreq = 16'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    model(50000, 3, 1'b0, 1'b0, e1, p1);
    w2 = int'(ctrlWord);
    check(w2 == e1, "R9 start while busy ignored", w2, e1);
    sawBusy = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || done) sawBusy = 1'b1;
    end
    check(!sawBusy && int'(ctrlWord) == e1, "R9 no queued restart", int'(ctrlWord), e1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule